// File: doc/BRIEF.md
# Punctured Parallel Turbo Encoder

This block turns one frame of information bits into a turbo-coded symbol stream. Two identical recursive systematic convolutional encoders work side by side: the first one walks the frame in natural order, the second walks the same frame in a scrambled order given by a fixed permutation table. Because the systematic output of both encoders is the information bit itself, each output symbol carries that bit once, together with one parity bit from each encoder.

A frame begins with a start pulse, which also selects the code rate. The block then takes the whole frame over a valid/ready bit stream into a buffer. After the frame is buffered, it emits one symbol per information bit in natural order over a valid/ready symbol stream. At rate 1/3 every symbol carries both parity bits. At rate 1/2 the parity bits are thinned on an alternating pattern, and the systematic bit is always kept. A two-bit mask on each symbol tells the receiver which parity bits are real.

The controller is a four-state machine. ST_IDLE waits for start (transition T_START, to ST_LOAD). ST_LOAD stores input bits until the last one of the frame arrives (T_LOADED, to ST_EMIT). ST_EMIT steps both encoders once for each symbol it issues, and after the final symbol is issued (T_LAST) it moves to ST_DRAIN. ST_DRAIN waits until that symbol is taken (T_DONE, back to ST_IDLE).

Top module: `tenc_top`

## Requirements
- R1: A pulse on `start_i` while idle begins a frame and captures `half_rate_i` (1 = rate 1/2, 0 = rate 1/3) for the whole frame; `start_i` and `half_rate_i` have no effect at any other time.
- R2: After start, `in_ready_o` is high until exactly FRAME_LEN bits have been accepted and low otherwise, and no symbol is offered while bits are being loaded.
- R3: Exactly FRAME_LEN symbols follow each frame, in natural order k = 0..FRAME_LEN-1, and `out_sys_o` of symbol k equals input bit k.
- R4: Parity 1 comes from a recursive encoder on the natural-order bits with memory s1,s2: a = u^s1^s2, parity = a^s2, then s2 takes s1 and s1 takes a (feedback 1+D+D², feedforward 1+D²).
- R5: Parity 2 of symbol k comes from the same code applied to input bit π(k), where π(k) = (3k + 20k²) mod FRAME_LEN.
- R6: Both encoders start every frame from the all-zero state, whatever the previous frame left behind.
- R7: At rate 1/3 every symbol has `out_mask_o` = 2'b11. Mask bit 0 marks parity 1 as present, and mask bit 1 marks parity 2 as present.
- R8: At rate 1/2, even-index symbols have mask 2'b01 and odd-index symbols have mask 2'b10. A parity bit that is not present reads as 0, and the systematic bit is never removed.
- R9: A symbol stays valid and unchanged while `out_ready_i` is low, and it is taken on a clock where both `out_valid_o` and `out_ready_i` are high.
- R10: Once the last symbol is taken, `out_valid_o` and `in_ready_o` are both low and the block accepts a new start.
- R11: `in_valid_i` outside the loading phase is ignored and transfers no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start pulse |
| half_rate_i | input | 1 | Rate select captured at start: 1 = rate 1/2 |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Block can take an input bit |
| in_bit_i | input | 1 | Information bit |
| out_valid_o | output | 1 | Symbol valid |
| out_ready_i | input | 1 | Downstream takes the symbol |
| out_sys_o | output | 1 | Systematic bit |
| out_par1_o | output | 1 | Parity from the natural-order encoder |
| out_par2_o | output | 1 | Parity from the permuted-order encoder |
| out_mask_o | output | 2 | Parity presence: bit 0 parity 1, bit 1 parity 2 |

## Verification
The assertions assume that the downstream side obeys the handshake, that is, its readiness decides only when a symbol is taken. They also assume that the reset is released synchronously before the first start pulse. The stimulus applies ready patterns that stall for one or more cycles, input gaps, stray `in_valid_i` while idle and while emitting, and a start pulse plus a rate flip in the middle of a frame. The stray start and rate flip must change nothing. One frame with a single set bit follows a random frame, so that any state left in the encoders would show up in its parity streams.

// File: rtl/tenc_pkg.sv
package tenc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_EMIT,
        ST_DRAIN
    } tenc_state_e;

    // Quadratic permutation k -> (f1*k + f2*k*k) mod n, evaluated at elaboration.
    function automatic int qpp_index(input int k, input int n, input int f1, input int f2);
        longint t;
        t = (longint'(f1) * k + longint'(f2) * k * k) % n;
        return int'(t);
    endfunction

endpackage

// File: rtl/tenc_rsc.sv
module tenc_rsc #(
    parameter int             MEM     = 2,
    parameter logic [MEM:0]   FB_POLY = 3'b111,
    parameter logic [MEM:0]   FF_POLY = 3'b101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    input  logic bit_i,
    output logic parity_o
);

    // st[i-1] holds the D^i delay element
    logic [MEM-1:0] st;
    logic           fb;

    always_comb begin
        fb       = bit_i ^ (^(st & FB_POLY[MEM:1]));
        parity_o = (FF_POLY[0] & fb) ^ (^(st & FF_POLY[MEM:1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       st <= '0;
        else if (clear_i) st <= '0;
        else if (step_i)  st <= {st[MEM-2:0], fb};
    end

    // R6: a frame start leaves the encoder in the zero state
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st == '0));

endmodule

// File: rtl/tenc_perm_rom.sv
module tenc_perm_rom import tenc_pkg::*; #(
    parameter int FRAME_LEN = 400,
    parameter int PERM_F1   = 3,
    parameter int PERM_F2   = 20,
    parameter int AW        = $clog2(FRAME_LEN)
) (
    input  logic [AW-1:0] idx_i,
    output logic [AW-1:0] perm_o
);

    logic [AW-1:0] rom [FRAME_LEN];

    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_entry
        assign rom[g] = AW'(qpp_index(g, FRAME_LEN, PERM_F1, PERM_F2));
    end

    assign perm_o = rom[idx_i];

endmodule

// File: rtl/tenc_frame_buf.sv
module tenc_frame_buf #(
    parameter int FRAME_LEN = 400,
    parameter int AW        = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic          wr_bit_i,
    input  logic [AW-1:0] rd_a_addr_i,
    output logic          rd_a_bit_o,
    input  logic [AW-1:0] rd_b_addr_i,
    output logic          rd_b_bit_o
);

    logic [FRAME_LEN-1:0] mem;

    always_ff @(posedge clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_bit_i;
    end

    assign rd_a_bit_o = mem[rd_a_addr_i];
    assign rd_b_bit_o = mem[rd_b_addr_i];

endmodule

// File: rtl/tenc_top.sv
module tenc_top import tenc_pkg::*; #(
    parameter int FRAME_LEN = 400,
    parameter int PERM_F1   = 3,
    parameter int PERM_F2   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       half_rate_i,
    input  logic       in_valid_i,
    output logic       in_ready_o,
    input  logic       in_bit_i,
    output logic       out_valid_o,
    input  logic       out_ready_i,
    output logic       out_sys_o,
    output logic       out_par1_o,
    output logic       out_par2_o,
    output logic [1:0] out_mask_o
);

    localparam int            AW       = $clog2(FRAME_LEN);
    localparam logic [AW-1:0] LAST_IDX = AW'(FRAME_LEN - 1);
    localparam logic [AW:0]   LEN_W    = (AW+1)'(FRAME_LEN);

    tenc_state_e   state, nstate;
    logic [AW-1:0] idx;
    logic [AW-1:0] perm_idx;
    logic          half_q;
    logic          at_last, accept, advance, taken, kick;
    logic          u_nat, u_perm, p1_raw, p2_raw;
    logic [1:0]    mask_now;

    assign at_last    = (idx == LAST_IDX);
    assign in_ready_o = (state == ST_LOAD);
    assign accept     = in_valid_i && in_ready_o;
    assign advance    = (state == ST_EMIT) && (!out_valid_o || out_ready_i);
    assign taken      = out_valid_o && out_ready_i;
    assign kick       = (state == ST_IDLE) && start_i;
    assign mask_now   = half_q ? (idx[0] ? 2'b10 : 2'b01) : 2'b11;

    tenc_frame_buf #(.FRAME_LEN(FRAME_LEN), .AW(AW)) u_buf (
        .clk         (clk),
        .wr_en_i     (accept),
        .wr_addr_i   (idx),
        .wr_bit_i    (in_bit_i),
        .rd_a_addr_i (idx),
        .rd_a_bit_o  (u_nat),
        .rd_b_addr_i (perm_idx),
        .rd_b_bit_o  (u_perm)
    );

    tenc_perm_rom #(.FRAME_LEN(FRAME_LEN), .PERM_F1(PERM_F1), .PERM_F2(PERM_F2), .AW(AW)) u_rom (
        .idx_i  (idx),
        .perm_o (perm_idx)
    );

    tenc_rsc u_enc_nat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (kick),
        .step_i   (advance),
        .bit_i    (u_nat),
        .parity_o (p1_raw)
    );

    tenc_rsc u_enc_perm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (kick),
        .step_i   (advance),
        .bit_i    (u_perm),
        .parity_o (p2_raw)
    );

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start_i)            nstate = ST_LOAD;   // T_START
            ST_LOAD:  if (accept && at_last)  nstate = ST_EMIT;   // T_LOADED
            ST_EMIT:  if (advance && at_last) nstate = ST_DRAIN;  // T_LAST
            ST_DRAIN: if (taken)              nstate = ST_IDLE;   // T_DONE
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx         <= '0;
            half_q      <= 1'b0;
            out_valid_o <= 1'b0;
            out_sys_o   <= 1'b0;
            out_par1_o  <= 1'b0;
            out_par2_o  <= 1'b0;
            out_mask_o  <= 2'b00;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        idx    <= '0;
                        half_q <= half_rate_i;
                    end
                end
                ST_LOAD: begin
                    if (accept) idx <= at_last ? '0 : idx + 1'b1;
                end
                ST_EMIT: begin
                    if (advance) begin
                        out_valid_o <= 1'b1;
                        out_sys_o   <= u_nat;
                        out_par1_o  <= p1_raw & mask_now[0];
                        out_par2_o  <= p2_raw & mask_now[1];
                        out_mask_o  <= mask_now;
                        idx         <= at_last ? '0 : idx + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (taken) out_valid_o <= 1'b0;
                end
            endcase
        end
    end

    assert_load_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> !out_valid_o);

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_sys_o) &&
            $stable(out_par1_o) && $stable(out_par2_o) && $stable(out_mask_o)));

    assert_mask_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_mask_o != 2'b00));

    assert_punct_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((out_mask_o[0] || !out_par1_o) && (out_mask_o[1] || !out_par2_o)));

    assert_perm_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |-> ({1'b0, perm_idx} < LEN_W));

endmodule

// File: tb/test_tenc_top.sv
module test_tenc_top;

    localparam int LEN = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, half_rate_i = 1'b0;
    logic       in_valid_i = 1'b0, in_bit_i = 1'b0;
    logic       in_ready_o;
    logic       out_valid_o, out_ready_i = 1'b0;
    logic       out_sys_o, out_par1_o, out_par2_o;
    logic [1:0] out_mask_o;

    int n_cmp = 0;
    int n_bad = 0;

    bit       fbits  [LEN];
    bit       e_sys  [LEN];
    bit       e_p1   [LEN];
    bit       e_p2   [LEN];
    bit [1:0] e_mask [LEN];

    always #4 clk = ~clk;

    tenc_top i_tenc_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_rate_i(half_rate_i),
        .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_bit_i(in_bit_i),
        .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_sys_o(out_sys_o),
        .out_par1_o(out_par1_o), .out_par2_o(out_par2_o), .out_mask_o(out_mask_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int perm(input int k);
        return (3 * k + 20 * k * k) % LEN;
    endfunction

    // behavioural reference of the coded stream (R3 R4 R5 R7 R8)
    task automatic build_expected(input bit half);
        bit a1 = 0, b1 = 0, a2 = 0, b2 = 0;
        for (int k = 0; k < LEN; k++) begin
            bit u = fbits[k];
            bit v = fbits[perm(k)];
            bit f1 = u ^ a1 ^ b1;
            bit f2 = v ^ a2 ^ b2;
            bit [1:0] m = half ? ((k % 2 == 1) ? 2'b10 : 2'b01) : 2'b11;
            e_sys[k]  = u;
            e_p1[k]   = (f1 ^ b1) & m[0];
            e_p2[k]   = (f2 ^ b2) & m[1];
            e_mask[k] = m;
            b1 = a1; a1 = f1;
            b2 = a2; a2 = f2;
        end
    endtask

    task automatic run_frame(input bit half, input int rmode, input int gmode, input bit poke,
                             input string mreq);
        int in_idx = 0;
        int out_idx = 0;
        int cyc = 0;
        build_expected(half);
        @(negedge clk);
        start_i = 1'b1; half_rate_i = half;
        @(negedge clk);
        start_i = 1'b0; half_rate_i = !half;   // rate change after start: R1
        while (out_idx < LEN && cyc < 20000) begin
            check(in_ready_o == (in_idx < LEN), "R2 in_ready", int'(in_ready_o), int'(in_idx < LEN));
            if (in_idx < LEN)
                check(!out_valid_o, "R2 quiet_load", int'(out_valid_o), 0);
            start_i = poke && (in_idx == LEN / 2);   // stray start: R1
            if (in_idx < LEN) begin
                in_valid_i = (gmode == 0) ? 1'b1 : (cyc % 4 != 2);
                in_bit_i   = fbits[in_idx];
            end else begin
                in_valid_i = (cyc % 3 == 0);         // stray valid: R11
                in_bit_i   = cyc[0];
            end
            case (rmode)
                0:       out_ready_i = 1'b1;
                1:       out_ready_i = (cyc % 3 != 1);
                default: out_ready_i = ((cyc * 7) % 5) < 2;
            endcase
            if (in_valid_i && in_ready_o) in_idx++;
            if (out_valid_o && out_ready_i) begin
                check(out_sys_o == e_sys[out_idx], "R3 sys", int'(out_sys_o), int'(e_sys[out_idx]));
                check(out_par1_o == e_p1[out_idx], "R4 R6 par1", int'(out_par1_o), int'(e_p1[out_idx]));
                check(out_par2_o == e_p2[out_idx], "R5 R6 par2", int'(out_par2_o), int'(e_p2[out_idx]));
                check(out_mask_o == e_mask[out_idx], mreq, int'(out_mask_o), int'(e_mask[out_idx]));
                out_idx++;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0; in_valid_i = 1'b0; out_ready_i = 1'b0;
        check(out_idx == LEN, "R3 symbol_count", out_idx, LEN);
        check(!out_valid_o, "R10 valid_low", int'(out_valid_o), 0);
        check(!in_ready_o, "R10 ready_low", int'(in_ready_o), 0);
    endtask

    task automatic idle_noise();
        for (int c = 0; c < 5; c++) begin
            in_valid_i = 1'b1; in_bit_i = 1'b1;
            @(negedge clk);
            check(!in_ready_o, "R11 idle_ready", int'(in_ready_o), 0);
            check(!out_valid_o, "R11 idle_valid", int'(out_valid_o), 0);
        end
        in_valid_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed = 32'h1d872b41;
        repeat (3) @(negedge clk);
        check(!in_ready_o, "R2 reset_ready", int'(in_ready_o), 0);
        check(!out_valid_o, "R9 reset_valid", int'(out_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_noise();

        for (int k = 0; k < LEN; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            fbits[k] = seed[3];
        end
        run_frame(1'b0, 0, 0, 1'b0, "R7 mask");

        for (int k = 0; k < LEN; k++) fbits[k] = (k == 0);
        run_frame(1'b1, 1, 0, 1'b0, "R8 mask");

        idle_noise();
        for (int k = 0; k < LEN; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            fbits[k] = seed[7];
        end
        run_frame(1'b1, 2, 1, 1'b1, "R1 R8 mask");

        for (int k = 0; k < LEN; k++) fbits[k] = 1'b1;
        run_frame(1'b0, 1, 1, 1'b1, "R1 R7 mask");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule